// File: doc/BRIEF.md
# Display Processor DMA Request Controller

This block is the register-facing control logic of a display processor that decides whether a DMA request is raised toward the system DMA controller. Software writes 32-bit command words to a control port. The top byte of each word selects a command and the low 24 bits carry its parameter. One command sets a 2-bit transfer direction. While that direction is anything other than off, the block raises its DMA request line and reports the request in a status bit.

A single offset-addressed port gives combinational reads of a data port, which returns a fixed placeholder word, and of the status word. A DMA-side read port returns data only while the direction selects transfers from the read port to the CPU. In any other direction it returns all ones and flags an error. Words written from the DMA side are taken and discarded. A soft reset input returns the status word to its initial value.

Top module: `disp_dma_ctl`

## Requirements
- R1: After hard reset (rst_n low) or a soft_rst pulse, a status read (offset 0x04) returns 0x14802000, dma_req is 0 and unsup_cmd is 0.
- R2: A write to offset 0x04 whose bits 31:24 equal 0x04 loads the direction from bits 1:0 and ignores bits 23:2. The new value shows in status bits 30:29 from the cycle after the write. Codes: 0 off, 1 fifo, 2 cpu-to-command-port, 3 read-port-to-cpu.
- R3: dma_req and status bit 25 are both 1 exactly when the direction is nonzero, and both follow a direction write in the next cycle. All other status bits keep their reset value.
- R4: Reads at offset 0x00 return DATA_FILL (default 0x00000000), reads at offset 0x04 return the status word, and reads at any other offset return 0xFFFFFFFF.
- R5: While dma_rd is high, dma_rdata is DATA_FILL and dma_rd_err is 0 when the direction is 3. For any other direction dma_rdata is 0xFFFFFFFF and dma_rd_err is 1 in the same cycle. dma_rd_err is 0 whenever dma_rd is low.
- R6: A control-port write with any command byte other than 0x04 leaves the direction unchanged and sets unsup_cmd. unsup_cmd stays set until a reset or soft reset.
- R7: Writes to offset 0x00, writes to unmapped offsets and dma_wr words change neither the status word, nor dma_req, nor unsup_cmd.
- R8: soft_rst takes priority over a control-port write in the same cycle: the direction is cleared and unsup_cmd is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | OFF_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| dma_rd | input | 1 | DMA-side read strobe |
| dma_rdata | output | 32 | DMA-side read data |
| dma_rd_err | output | 1 | DMA read attempted in the wrong direction |
| dma_wr | input | 1 | DMA-side write strobe (word discarded) |
| dma_wdata | input | 32 | DMA-side write data |
| dma_req | output | 1 | DMA request toward the DMA controller |
| unsup_cmd | output | 1 | Sticky flag for an unrecognised control command |

## Verification
The hardest case to reach from the ports is a control write and a soft reset in the same cycle. The bench first puts the block into a nonzero direction with unsup_cmd set, then drives a direction command together with soft_rst, and checks that the reset values win. The bench also walks all four direction codes, and for each code it reads the status word and issues a DMA read. This covers the one code where a DMA read succeeds and the three where it fails. A direction write that carries stray parameter bits shows that only bits 1:0 are used.

// File: rtl/disp_dma_ctl.sv
module disp_dma_ctl #(
  parameter int          OFF_W     = 8,
  parameter logic [31:0] STAT_INIT = 32'h1480_2000,
  parameter logic [31:0] DATA_FILL = 32'h0000_0000,
  parameter logic [7:0]  CMD_DIR   = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_wr,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dma_rd,
  output logic [31:0]      dma_rdata,
  output logic             dma_rd_err,
  input  logic             dma_wr,
  input  logic [31:0]      dma_wdata,
  output logic             dma_req,
  output logic             unsup_cmd
);
  localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_CTRL = OFF_W'(4);
  localparam logic [1:0]       DIR_RD   = 2'd3;

  logic [1:0]  dir;
  logic        ctl_wr;
  logic [31:0] stat;

  assign ctl_wr = reg_wr && (reg_off == OFF_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir       <= STAT_INIT[30:29];
      unsup_cmd <= 1'b0;
    end else if (soft_rst) begin
      dir       <= STAT_INIT[30:29];
      unsup_cmd <= 1'b0;
    end else if (ctl_wr) begin
      if (reg_wdata[31:24] == CMD_DIR) dir <= reg_wdata[1:0];
      else                             unsup_cmd <= 1'b1;
    end
  end

  assign dma_req = (dir != 2'd0);
  assign stat    = {STAT_INIT[31], dir, STAT_INIT[28:26], dma_req, STAT_INIT[24:0]};

  always_comb begin
    if (reg_off == OFF_DATA)      reg_rdata = DATA_FILL;
    else if (reg_off == OFF_CTRL) reg_rdata = stat;
    else                          reg_rdata = 32'hFFFF_FFFF;
  end

  assign dma_rdata  = (dir == DIR_RD) ? DATA_FILL : 32'hFFFF_FFFF;
  assign dma_rd_err = dma_rd && (dir != DIR_RD);

  logic unused_ok;
  assign unused_ok = ^{dma_wr, dma_wdata};
endmodule

// File: rtl/disp_dma_ctl_chk.sv
module disp_dma_ctl_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             reg_wr,
  input logic [OFF_W-1:0] reg_off,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             dma_rd,
  input logic [31:0]      dma_rdata,
  input logic             dma_rd_err,
  input logic             dma_req,
  input logic             unsup_cmd,
  input logic [1:0]       dir
);
  logic ctl;
  assign ctl = reg_wr && (reg_off == OFF_W'(4)) && !soft_rst;

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl && reg_wdata[31:24] == 8'h04 |=> dir == $past(reg_wdata[1:0]));

  a_r3_req_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
    reg_off == OFF_W'(4) |-> (dma_req == reg_rdata[25]) && (dma_req == (reg_rdata[30:29] != 2'd0)));

  a_r4_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
    reg_off != OFF_W'(0) && reg_off != OFF_W'(4) |-> reg_rdata == 32'hFFFF_FFFF);

  a_r5_err_gives_ones: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_err |-> dma_rd && dma_rdata == 32'hFFFF_FFFF);

  a_r6_unsup_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ctl && reg_wdata[31:24] != 8'h04 |=> $stable(dir) && unsup_cmd);

  a_r6_unsup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_cmd && !soft_rst |=> unsup_cmd);

  a_r8_soft_wins: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> dir == 2'd0 && !unsup_cmd && !dma_req);
endmodule

bind disp_dma_ctl disp_dma_ctl_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
  .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .dma_rd(dma_rd), .dma_rdata(dma_rdata), .dma_rd_err(dma_rd_err),
  .dma_req(dma_req), .unsup_cmd(unsup_cmd), .dir(dir)
);

// File: tb/tb_disp_dma_ctl.sv
module tb_disp_dma_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT = 32'h1480_2000;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, reg_wr = 1'b0, dma_rd = 1'b0, dma_wr = 1'b0;
  logic [7:0] reg_off = 8'h00;
  logic [31:0] reg_wdata = '0, dma_wdata = '0;
  logic [31:0] reg_rdata, dma_rdata;
  logic dma_rd_err, dma_req, unsup_cmd;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_dma_ctl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .dma_rd_err(dma_rd_err), .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_req(dma_req),
    .unsup_cmd(unsup_cmd)
  );

  function automatic logic [31:0] exp_stat(input logic [1:0] d);
    return INIT | (32'(d) << 29) | ((d != 2'd0) ? 32'h0200_0000 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_off = 8'h04;
    #1;
  endtask

  task automatic status(input string req, input logic [1:0] d, input logic u);
    reg_off = 8'h04; #1;
    chk(req, reg_rdata, exp_stat(d));
    chk(req, {31'd0, dma_req}, {31'd0, d != 2'd0});
    chk(req, {31'd0, unsup_cmd}, {31'd0, u});
  endtask

  task automatic t_reset;
    status("R1", 2'd0, 1'b0);
  endtask

  task automatic t_dirs;
    for (int d = 0; d < 4; d++) begin
      wr(8'h04, 32'h0400_0000 | 32'(d));
      status("R2 R3", 2'(d), 1'b0);
      dma_rd = 1'b1; #1;
      chk("R5 data", dma_rdata, (d == 3) ? 32'h0 : 32'hFFFF_FFFF);
      chk("R5 err", {31'd0, dma_rd_err}, {31'd0, d != 3});
      dma_rd = 1'b0; #1;
      chk("R5 idle", {31'd0, dma_rd_err}, 32'd0);
    end
    wr(8'h04, 32'h04FF_FFFE);
    status("R2 param", 2'd2, 1'b0);
  endtask

  task automatic t_reads;
    reg_off = 8'h00; #1; chk("R4 data", reg_rdata, 32'h0);
    reg_off = 8'h08; #1; chk("R4 unmapped", reg_rdata, 32'hFFFF_FFFF);
    reg_off = 8'h05; #1; chk("R4 unmapped", reg_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored;
    wr(8'h00, 32'h0400_0001);
    wr(8'h0C, 32'h0500_0003);
    @(negedge clk); dma_wr = 1'b1; dma_wdata = 32'h0400_0000;
    @(negedge clk); dma_wr = 1'b0; #1;
    status("R7", 2'd2, 1'b0);
  endtask

  task automatic t_unsup;
    wr(8'h04, 32'h0800_0001);
    status("R6", 2'd2, 1'b1);
    wr(8'h04, 32'h0400_0003);
    status("R6 sticky", 2'd3, 1'b1);
  endtask

  task automatic t_soft;
    @(negedge clk); soft_rst = 1'b1; reg_wr = 1'b1; reg_off = 8'h04; reg_wdata = 32'h0400_0001;
    @(negedge clk); soft_rst = 1'b0; reg_wr = 1'b0; #1;
    status("R8", 2'd0, 1'b0);
    status("R1 soft", 2'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset; t_dirs; t_reads; t_ignored; t_unsup; t_soft;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule